// File: doc/BRIEF.md
# Column-Bypassing Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is an array multiplier: partial-product bits are formed by AND gates and placed by wiring alone. They are summed by N-1 rows of carry-save cells, and a ripple-carry row then resolves the leftover sums and carries into the upper half of the product.

Every adder cell has a gating input. In column mode, each multiplicand bit drives the gating input of the vertical chain of cells that handles that bit. When the bit is zero, those cells isolate their adder inputs. Each cell copies the incoming sum straight to its sum output and holds its carry output at the chain's resting value of zero, so the gated adders produce no switching.

A parameter selects a row variant, in which the multiplier bits drive the gating inputs instead. A second parameter chooses a registered product, with one cycle of latency, or a purely combinational one.

Top module: `colbyp_mult`

## Requirements
- R1: For every pair of unsigned operands, the product output equals a times b as a 2N-bit unsigned value.
- R2: When the multiplicand has only bit i set, the product equals the multiplier shifted left by i places. This holds for every i from 0 to N-1.
- R3: In column mode, cells whose multiplicand bit is 0 are bypassed. Each such cell forwards its incoming sum to its sum output and drives a carry of 0. Multiplicands with several zero bits therefore still give the exact product.
- R4: With MODE set to the row variant, the gating comes from the multiplier bits b. The product is the same as in R1 for every operand pair.
- R5: With REG_OUT = 1, the product of the operands present at a rising clock edge appears after that edge and holds until the next edge. With REG_OUT = 0, the product follows the operands within the same cycle.
- R6: With REG_OUT = 1, a low rst_n at a rising edge clears the product to 0, whatever the operands are. Reset takes priority over capture.
- R7: If either operand is zero, the product is zero.
- R8: When both operands are all ones, the product is (2^N-1)^2, which is 16'hFE01 for N = 8. This needs carries to reach the top product bit 2N-1.
- R9: When the multiplicand is 1, the product equals the multiplier, zero-extended to 2N bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | N | Unsigned multiplicand; in column mode its bits drive the gating |
| b | input | N | Unsigned multiplier; in row mode its bits drive the gating |
| prod | output | 2N | Unsigned product a*b |

## Verification
The bound checker compares the product on every clock edge with an arithmetic multiply of the operands captured one edge earlier. On every edge it also checks that reset clears the output, that a zero operand yields zero, and that a unit multiplicand passes the multiplier through.

Some properties only the bench scenarios can show. The bench sweeps every operand pair in both gating variants, so every pattern of bypassed columns and rows is exercised. It also shows the single-cycle latency by sampling inside the cycle, and shows that reset wins over non-zero operands in the middle of a run.

// File: rtl/cbm_pkg.sv
// Package: shared types for the column-bypassing multiplier.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package cbm_pkg;

    // Which operand drives the gating inputs of the adder cells.
    typedef enum logic {
        BYP_COLUMN = 1'b0,  // multiplicand bits gate the vertical cell chains
        BYP_ROW    = 1'b1   // multiplier bits gate them instead
    } cbm_bypass_e;

endpackage

// File: rtl/cbm_gated_fa.sv
// Gated full-adder cell.
// When en is high, the cell adds pp, sum_i and carry_i.
// When en is low, its adder inputs are isolated: sum_i is passed to sum_o,
// and carry_o rests at zero.
// Assumes the carry entering a disabled cell is itself zero. The array
// guarantees this, because carries travel inside the same gated chain.
module cbm_gated_fa (
    input  logic en,
    input  logic pp,
    input  logic sum_i,
    input  logic carry_i,
    output logic sum_o,
    output logic carry_o
);
    logic x_g, s_g, c_g;
    logic fa_sum, fa_carry;

    // Operand isolation: the adder sees constant zeros while bypassed.
    always_comb begin
        x_g = en & pp;
        s_g = en & sum_i;
        c_g = en & carry_i;
    end

    // Full-adder equations on the isolated operands.
    always_comb begin
        fa_sum   = x_g ^ s_g ^ c_g;
        fa_carry = (x_g & s_g) | (x_g & c_g) | (s_g & c_g);
    end

    // Bypass mux: pass the incoming sum through, and hold the carry at rest.
    always_comb begin
        sum_o   = en ? fa_sum   : sum_i;
        carry_o = en ? fa_carry : 1'b0;
    end
endmodule

// File: rtl/cbm_csa_array.sv
// Carry-save array of the multiplier.
// Row 0 holds the plain partial products col_op[i] & row_op[0].
// Each row r = 1..N-1 has one gated cell per column i, of weight i+r.
// A cell's sum moves to the cell one column lower in the next row, keeping
// its weight. Its carry stays in the same column in the next row, which
// raises its weight by one. Every cell in column i is gated by col_op[i].
// Outputs: the low product bits, plus the last row's sums and carries,
// aligned to weights N..2N-1 for the ripple row.
// Assumes N >= 2.
module cbm_csa_array #(
    parameter int N = 8
) (
    input  logic [N-1:0] col_op,
    input  logic [N-1:0] row_op,
    output logic [N-1:0] low_bits,
    output logic [N-1:0] sum_top,
    output logic [N-1:0] carry_top
);
    localparam int CELLS = N * N;

    logic [CELLS-1:0] s_w;   // sum of row r, column i at index r*N+i
    logic [CELLS-1:0] c_w;   // carry of row r, column i at index r*N+i

    // Row 0: the first partial-product row enters the array directly.
    for (genvar i = 0; i < N; i++) begin : g_row0
        assign s_w[i] = col_op[i] & row_op[0];
        assign c_w[i] = 1'b0;
    end

    // Rows 1..N-1: carry-save cells, gated per column.
    for (genvar r = 1; r < N; r++) begin : g_row
        for (genvar i = 0; i < N; i++) begin : g_col
            logic sum_in;
            if (i == N - 1) begin : g_top
                assign sum_in = 1'b0;
            end else begin : g_mid
                assign sum_in = s_w[(r-1)*N + i + 1];
            end
            cbm_gated_fa u_cell (
                .en      (col_op[i]),
                .pp      (col_op[i] & row_op[r]),
                .sum_i   (sum_in),
                .carry_i (c_w[(r-1)*N + i]),
                .sum_o   (s_w[r*N + i]),
                .carry_o (c_w[r*N + i])
            );
        end
    end

    // Lower product bits leave column 0 of each row.
    for (genvar r = 0; r < N; r++) begin : g_low
        assign low_bits[r] = s_w[r*N];
    end

    // Last-row terms, aligned so that bit k has weight N+k.
    for (genvar k = 0; k < N; k++) begin : g_out
        if (k == N - 1) begin : g_msb
            assign sum_top[k] = 1'b0;
        end else begin : g_rest
            assign sum_top[k] = s_w[(N-1)*N + k + 1];
        end
        assign carry_top[k] = c_w[(N-1)*N + k];
    end
endmodule

// File: rtl/cbm_ripple_row.sv
// Final ripple-carry row: adds two N-bit vectors of equal weight and
// returns the N-bit sum.
// Assumes the true result fits in N bits, which holds for the upper half
// of an N x N product, so the final carry is not formed.
module cbm_ripple_row #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] hi
);
    logic [N-1:0] rc;   // carry entering each bit position

    assign rc[0] = 1'b0;

    // One full adder per bit; the carry moves toward the MSB.
    for (genvar k = 0; k < N; k++) begin : g_bit
        assign hi[k] = x[k] ^ y[k] ^ rc[k];
        if (k < N - 1) begin : g_carry
            assign rc[k+1] = (x[k] & y[k]) | (x[k] & rc[k]) | (y[k] & rc[k]);
        end
    end
endmodule

// File: rtl/colbyp_mult.sv
// Top module: unsigned N x N array multiplier with gated adder cells.
// MODE picks the operand whose bits gate the cell chains.
// REG_OUT = 1 adds an output register with a synchronous active-low reset.
// Assumes N >= 2. Operands are unsigned.
module colbyp_mult
    import cbm_pkg::*;
#(
    parameter int          N       = 8,
    parameter cbm_bypass_e MODE    = BYP_COLUMN,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] prod
);
    localparam int PW = 2 * N;

    logic [N-1:0]  col_op, row_op;
    logic [N-1:0]  low_bits, sum_top, carry_top, hi_bits;
    logic [PW-1:0] prod_comb;

    // Gating source: the array gates on col_op, so route the chosen operand there.
    if (MODE == BYP_ROW) begin : g_row_mode
        assign col_op = b;
        assign row_op = a;
    end else begin : g_col_mode
        assign col_op = a;
        assign row_op = b;
    end

    cbm_csa_array #(.N(N)) u_array (
        .col_op    (col_op),
        .row_op    (row_op),
        .low_bits  (low_bits),
        .sum_top   (sum_top),
        .carry_top (carry_top)
    );

    cbm_ripple_row #(.N(N)) u_ripple (
        .x  (sum_top),
        .y  (carry_top),
        .hi (hi_bits)
    );

    assign prod_comb = {hi_bits, low_bits};

    if (REG_OUT) begin : g_reg
        // Output register: reset clears it, otherwise it captures the product.
        always_ff @(posedge clk) begin
            if (!rst_n) prod <= '0;
            else        prod <= prod_comb;
        end
    end else begin : g_comb
        assign prod = prod_comb;
    end
endmodule

// File: rtl/colbyp_mult_chk.sv
// Checker for colbyp_mult, bound to every instance.
// It compares the port-level behaviour with arithmetic multiplication.
// Assumes operands are stable around the rising clock edge.
module colbyp_mult_chk #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic [2*N-1:0] prod
);
    // Reference multiply at full product width.
    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        return {{N{1'b0}}, x} * {{N{1'b0}}, y};
    endfunction

    if (REG_OUT) begin : g_reg_chk
        // R1 / R5: the product of the previous edge's operands appears after that edge.
        p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> prod == ref_mul($past(a), $past(b)));
        // R6: reset at an edge leaves a zero product after it.
        p_reset_clear_r6: assert property (@(posedge clk)
            !rst_n |=> prod == '0);
        // R7: a zero operand gives a zero product.
        p_zero_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |=> prod == '0);
        // R9: a unit multiplicand passes the multiplier through.
        p_unit_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (a == N'(1)) |=> prod == {{N{1'b0}}, $past(b)});
    end else begin : g_comb_chk
        // R1 / R5: the combinational product matches at every edge.
        p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            prod == ref_mul(a, b));
        // R7: a zero operand gives a zero product.
        p_zero_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |-> prod == '0);
        // R9: a unit multiplicand passes the multiplier through.
        p_unit_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (a == N'(1)) |-> prod == {{N{1'b0}}, b});
        // R8: all-ones operands reach the maximum product.
        p_max_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '1 && b == '1) |-> prod == ref_mul('1, '1));
    end
endmodule

bind colbyp_mult colbyp_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .prod  (prod)
);

// File: tb/test_colbyp_mult.sv
// Bench: one registered column-mode instance and one combinational row-mode
// instance, both checked each clock against a behavioural model.
module test_colbyp_mult;
    import cbm_pkg::*;

    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 150000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   a = '0;
    logic [W-1:0]   b = '0;
    logic [2*W-1:0] prod_reg, prod_row;
    logic [2*W-1:0] exp_q;
    int             total = 0;
    int             bad = 0;
    bit             done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2*W-1:0] mul(input logic [W-1:0] x, input logic [W-1:0] y);
        int unsigned r;
        r = int'(x) * int'(y);
        return r[2*W-1:0];
    endfunction

    // Behavioural model of the registered output.
    always @(posedge clk) exp_q <= !rst_n ? '0 : mul(a, b);

    colbyp_mult #(.N(W), .MODE(BYP_COLUMN), .REG_OUT(1'b1)) i_colbyp_mult (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(prod_reg)
    );

    colbyp_mult #(.N(W), .MODE(BYP_ROW), .REG_OUT(1'b0)) i_colbyp_mult_row (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .prod(prod_row)
    );

    task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, act, exp);
        end
    endtask

    // Drive at a falling edge, then check both outputs at the next falling edge.
    task automatic step(input logic [W-1:0] av, input logic [W-1:0] bv, input string tag);
        a = av;
        b = bv;
        @(negedge clk);
        check(tag, prod_reg, exp_q);
        check({tag, " R4 row"}, prod_row, mul(a, b));
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R6: reset clears the product even with non-zero operands.
        a = 8'hA5;
        b = 8'h3C;
        repeat (3) @(negedge clk);
        check("R6 reset", prod_reg, 16'h0000);
        rst_n = 1'b1;

        // R7: a zero operand on either side.
        step(8'h00, 8'hB7, "R7 zero a");
        step(8'h9D, 8'h00, "R7 zero b");
        check("R7 literal", prod_reg, 16'h0000);

        // R2: one-hot multiplicand, so the product is b shifted left by i.
        for (int i = 0; i < W; i++) begin
            step(8'(1 << i), 8'hC5, "R2 one-hot");
            check("R2 shift", prod_reg, 16'(16'h00C5 << i));
        end

        // R8: all ones.
        step(8'hFF, 8'hFF, "R8 max");
        check("R8 literal", prod_reg, 16'hFE01);

        // R9: unit multiplicand.
        step(8'h01, 8'h6B, "R9 unit");
        check("R9 literal", prod_reg, 16'h006B);

        // R3: sparse multiplicands, so several columns are bypassed.
        step(8'h81, 8'hFF, "R3 sparse");
        step(8'h24, 8'hE7, "R3 sparse");
        step(8'h10, 8'h99, "R3 sparse");
        step(8'hA0, 8'h5F, "R3 sparse");

        // R5: inside the cycle, the combinational output already shows the new
        // product, while the registered one still holds the old value.
        a = 8'h37;
        b = 8'h2E;
        #2;
        check("R5 comb same cycle", prod_row, mul(8'h37, 8'h2E));
        check("R5 reg holds", prod_reg, mul(8'hA0, 8'h5F));
        @(negedge clk);
        check("R5 reg after edge", prod_reg, mul(8'h37, 8'h2E));

        // R6: reset during the run takes priority over operands.
        rst_n = 1'b0;
        a = 8'hFF;
        b = 8'hFF;
        @(negedge clk);
        check("R6 mid reset", prod_reg, 16'h0000);
        rst_n = 1'b1;

        // R1 / R4: every operand pair.
        for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
                step(8'(ia), 8'(ib), "R1 sweep");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule